// File: doc/BRIEF.md
# Two-Wide Register Rename Unit with Committed-Map Recovery

This block sits between decode and the out-of-order backend. Every cycle it takes up to two decoded instructions, each with two architectural source operands and an optional architectural destination. It returns, in the same cycle, the physical tag of each source, a freshly allocated physical tag for each destination, and the physical tag that destination was mapped to before. Unused physical tags wait in a first-in first-out free list, and allocation always takes them from its head.

Two mapping tables are held. The speculative table follows every rename. The committed table follows only retired instructions. Retirement happens in program order: it records the retiring destination mapping in the committed table and returns the tag that mapping displaced to the tail of the free list. A flush after a misprediction copies the committed table into the speculative table. It also rewinds the free list so that every tag handed to a not-yet-retired instruction becomes free again.

The second instruction of a group may read or overwrite a register that the first one writes. In that case it sees the first instruction's new tag and not the stale table entry. Architectural register 0 is pinned to physical tag 0 and is never renamed.

Top module: `reg_rename`

## Requirements
- R1: After reset every architectural register r maps to physical tag r, and the free list holds tags 32 to 63 in ascending order, so the first two allocations return 32 and then 33.
- R2: A source naming architectural register 0 always returns physical tag 0. A destination of register 0 counts as no destination: it allocates nothing and its new and previous tag outputs read 0.
- R3: A slot allocates a tag only when it is valid, its destination write flag is set and its destination is not register 0. Allocations come from the free-list head, slot 0 before slot 1. A slot that does not allocate outputs 0 as its new tag.
- R4: A source tag, and the previous tag of a destination, equal the speculative mapping left by all earlier renamed groups.
- R5: When slot 0 allocates for register r, a slot 1 source naming r returns slot 0's new tag. If slot 1 also writes r, its previous tag is slot 0's new tag, and afterwards r maps to slot 1's new tag.
- R6: Ready is low when the free list holds fewer tags than the group needs (or in a flush cycle). In that cycle nothing is allocated and the speculative table is unchanged.
- R7: A commit of (register r, tag t), with r not 0, writes t into the committed table for r and pushes the tag previously committed for r onto the free-list tail. That tag is therefore handed out again only after every tag ahead of it.
- R8: A flush restores the speculative table from the committed table, including a commit in the same cycle. It returns all uncommitted allocations to the front of the free list in their allocation order, and renames nothing in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 2 | Per-slot instruction valid (bit 0 is the older slot) |
| ren_src_a | input | 10 | First source register per slot, 5 bits each, slot 0 in bits 4:0 |
| ren_src_b | input | 10 | Second source register per slot, same packing |
| ren_dst_we | input | 2 | Per-slot destination write flag |
| ren_dst | input | 10 | Destination register per slot, same packing |
| ren_ready | output | 1 | Group accepted this cycle |
| out_src_a | output | 12 | Physical tag of first source per slot, 6 bits each |
| out_src_b | output | 12 | Physical tag of second source per slot |
| out_dst_new | output | 12 | Newly allocated destination tag per slot, 0 if none |
| out_dst_old | output | 12 | Previous tag of the destination per slot, 0 if none |
| cmt_valid | input | 1 | Oldest in-flight destination retires this cycle |
| cmt_arch | input | 5 | Architectural register of the retiring destination |
| cmt_tag | input | 6 | Physical tag of the retiring destination |
| flush | input | 1 | Discard all speculative state and recover from the committed map |

## Verification
Several invariants are checked on every cycle: tag 0 stays pinned in both tables, the free list never underflows or overflows, the two tags granted in one group differ, a stalled cycle leaves the speculative table untouched, and the cycle after a flush shows the two tables equal. The actual tag values can only be shown by the bench's scenarios. These include the same-group forwarding of sources and previous tags, FIFO reuse order of retired tags, and the free-list rewind after a flush. The bench compares them against a queue-based model of free tags and in-flight allocations, driven through sweeps of colliding register numbers, exhaustion stalls and flushes that coincide with commits.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int NARCH = 32;
    localparam int NPHYS = 64;
    localparam int WIDTH = 2;
    localparam int AW    = $clog2(NARCH);
    localparam int PW    = $clog2(NPHYS);
    localparam int NFREE = NPHYS - NARCH;
    localparam int FW    = $clog2(NFREE);
    localparam int PTRW  = FW + 1;
    localparam int CW    = $clog2(WIDTH + 1);

    typedef logic [AW-1:0]   areg_t;
    typedef logic [PW-1:0]   ptag_t;
    typedef ptag_t [NARCH-1:0] map_t;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist
    import rn_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CW-1:0]       alloc_n,
    input  logic                push_en,
    input  ptag_t               push_tag,
    input  logic                cmt_pop,
    input  logic                flush,
    output ptag_t [WIDTH-1:0]   head_tags,
    output logic [PTRW-1:0]     free_cnt
);
    typedef struct packed {
        ptag_t [NFREE-1:0] mem;
        logic [PTRW-1:0]   head;
        logic [PTRW-1:0]   chead;
        logic [PTRW-1:0]   tail;
    } fl_t;

    fl_t fl_q, fl_d;

    function automatic fl_t fl_reset();
        fl_t r;
        for (int i = 0; i < NFREE; i++) r.mem[i] = PW'(NARCH + i);
        r.head  = '0;
        r.chead = '0;
        r.tail  = PTRW'(NFREE);
        return r;
    endfunction

    assign free_cnt = fl_q.tail - fl_q.head;

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_head
            assign head_tags[g] = fl_q.mem[fl_q.head[FW-1:0] + FW'(g)];
        end
    endgenerate

    always_comb begin
        fl_d = fl_q;
        if (push_en) begin
            fl_d.mem[fl_q.tail[FW-1:0]] = push_tag;
            fl_d.tail = fl_q.tail + PTRW'(1);
        end
        if (cmt_pop) fl_d.chead = fl_q.chead + PTRW'(1);
        if (flush) fl_d.head = fl_d.chead;
        else       fl_d.head = fl_q.head + PTRW'(alloc_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= fl_reset();
        else        fl_q <= fl_d;
    end

    // R6: never hand out more tags than are free
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        PTRW'(alloc_n) <= free_cnt);
    // R7: a returned tag always finds room
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> free_cnt < PTRW'(NFREE));
    // R8: no allocation in a flush cycle
    a_r8_no_alloc_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> alloc_n == '0);
endmodule

// File: rtl/rn_map_tables.sv
module rn_map_tables
    import rn_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   wr_en,
    input  areg_t [WIDTH-1:0]  wr_arch,
    input  ptag_t [WIDTH-1:0]  wr_tag,
    input  logic               cmt_en,
    input  areg_t              cmt_arch,
    input  ptag_t              cmt_tag,
    input  logic               flush,
    output map_t               spec_map,
    output map_t               cmt_map
);
    typedef struct packed {
        map_t spec;
        map_t cmt;
    } maps_t;

    maps_t mp_q, mp_d;

    function automatic maps_t maps_reset();
        maps_t r;
        for (int i = 0; i < NARCH; i++) begin
            r.spec[i] = PW'(i);
            r.cmt[i]  = PW'(i);
        end
        return r;
    endfunction

    always_comb begin
        mp_d = mp_q;
        if (cmt_en) mp_d.cmt[cmt_arch] = cmt_tag;
        if (flush) begin
            mp_d.spec = mp_d.cmt;
        end else begin
            // later slot written last so it wins on a shared destination
            for (int i = 0; i < WIDTH; i++)
                if (wr_en[i]) mp_d.spec[wr_arch[i]] = wr_tag[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mp_q <= maps_reset();
        else        mp_q <= mp_d;
    end

    assign spec_map = mp_q.spec;
    assign cmt_map  = mp_q.cmt;

    // R2: register 0 stays on tag 0 in both tables
    a_r2_zero_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        mp_q.spec[0] == '0 && mp_q.cmt[0] == '0);
    // R8: after a flush the speculative table equals the committed one
    a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> mp_q.spec == mp_q.cmt);
endmodule

// File: rtl/reg_rename.sv
module reg_rename
    import rn_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WIDTH-1:0]      ren_valid,
    input  logic [WIDTH*AW-1:0]   ren_src_a,
    input  logic [WIDTH*AW-1:0]   ren_src_b,
    input  logic [WIDTH-1:0]      ren_dst_we,
    input  logic [WIDTH*AW-1:0]   ren_dst,
    output logic                  ren_ready,
    output logic [WIDTH*PW-1:0]   out_src_a,
    output logic [WIDTH*PW-1:0]   out_src_b,
    output logic [WIDTH*PW-1:0]   out_dst_new,
    output logic [WIDTH*PW-1:0]   out_dst_old,
    input  logic                  cmt_valid,
    input  logic [AW-1:0]         cmt_arch,
    input  logic [PW-1:0]         cmt_tag,
    input  logic                  flush
);
    areg_t [WIDTH-1:0] sa, sb, dd;
    ptag_t [WIDTH-1:0] head_tags, new_tag, src_a_t, src_b_t, old_t;
    logic  [WIDTH-1:0] alloc, go_alloc;
    logic  [CW-1:0]    need;
    logic  [PTRW-1:0]  free_cnt;
    map_t              spec_map, cmt_map;
    logic              cmt_go;

    assign sa = ren_src_a;
    assign sb = ren_src_b;
    assign dd = ren_dst;

    // allocation: count destinations and take tags from the head in slot order
    always_comb begin
        int k;
        k = 0;
        need = '0;
        for (int i = 0; i < WIDTH; i++) begin
            alloc[i]   = ren_valid[i] & ren_dst_we[i] & (dd[i] != '0);
            new_tag[i] = alloc[i] ? head_tags[k] : '0;
            if (alloc[i]) k = k + 1;
            need = need + CW'(alloc[i]);
        end
    end

    assign ren_ready = !flush && (free_cnt >= PTRW'(need));
    assign go_alloc  = alloc & {WIDTH{ren_ready}};

    // table lookup with forwarding from older slots of the same group
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            src_a_t[i] = spec_map[sa[i]];
            src_b_t[i] = spec_map[sb[i]];
            old_t[i]   = spec_map[dd[i]];
            for (int j = 0; j < i; j++) begin
                if (alloc[j] && dd[j] == sa[i]) src_a_t[i] = new_tag[j];
                if (alloc[j] && dd[j] == sb[i]) src_b_t[i] = new_tag[j];
                if (alloc[j] && dd[j] == dd[i]) old_t[i]   = new_tag[j];
            end
            if (!alloc[i]) old_t[i] = '0;
        end
    end

    assign out_src_a   = src_a_t;
    assign out_src_b   = src_b_t;
    assign out_dst_new = new_tag;
    assign out_dst_old = old_t;

    assign cmt_go = cmt_valid && (cmt_arch != '0);

    rn_map_tables maps_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (go_alloc),
        .wr_arch  (dd),
        .wr_tag   (new_tag),
        .cmt_en   (cmt_go),
        .cmt_arch (cmt_arch),
        .cmt_tag  (cmt_tag),
        .flush    (flush),
        .spec_map (spec_map),
        .cmt_map  (cmt_map)
    );

    rn_freelist free_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_n   (ren_ready ? need : CW'(0)),
        .push_en   (cmt_go),
        .push_tag  (cmt_map[cmt_arch]),
        .cmt_pop   (cmt_go),
        .flush     (flush),
        .head_tags (head_tags),
        .free_cnt  (free_cnt)
    );

    // R3: two tags granted in one group are distinct
    a_r3_distinct_new: assert property (@(posedge clk) disable iff (!rst_n)
        (go_alloc[0] && go_alloc[1]) |-> new_tag[0] != new_tag[1]);
    // R6: a stalled non-flush cycle leaves the speculative table alone
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren_ready && !flush) |=> $stable(spec_map));
endmodule

// File: tb/reg_rename_tb_top.sv
`timescale 1ns/1ps
module reg_rename_tb_top;
    import rn_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic [1:0] ren_valid, ren_dst_we;
    logic [2*AW-1:0] ren_src_a, ren_src_b, ren_dst;
    logic ren_ready;
    logic [2*PW-1:0] out_src_a, out_src_b, out_dst_new, out_dst_old;
    logic cmt_valid, flush;
    logic [AW-1:0] cmt_arch;
    logic [PW-1:0] cmt_tag;

    reg_rename dut_i (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_src_a(ren_src_a),
        .ren_src_b(ren_src_b), .ren_dst_we(ren_dst_we), .ren_dst(ren_dst),
        .ren_ready(ren_ready), .out_src_a(out_src_a), .out_src_b(out_src_b),
        .out_dst_new(out_dst_new), .out_dst_old(out_dst_old), .cmt_valid(cmt_valid),
        .cmt_arch(cmt_arch), .cmt_tag(cmt_tag), .flush(flush)
    );

    int total = 0, bad = 0;
    int spec_m[NARCH], cmt_m[NARCH];
    int fq[$], inf_arch[$], inf_tag[$];
    bit recycled[NPHYS];
    bit post_flush = 0;
    int unsigned seed = 32'h1234_5678;

    function automatic int rnd(int m);
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'((seed >> 8) % m);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string src_lbl(int s, bit byp, bit first);
        if (s == 0) return "R2";
        if (byp) return "R5";
        if (post_flush) return "R8";
        if (first) return "R1";
        return "R4";
    endfunction

    task automatic step(bit [1:0] v, bit [1:0] we, int a0, int b0, int d0,
                        int a1, int b1, int d1, bit cv, bit fl, bit first);
        int sa[2], sb[2], dd[2], newt[2];
        bit al[2];
        int need, pos, ea, eb, eo;
        bit rdy, ba, bb, bo;
        string lb;
        sa[0] = a0; sa[1] = a1; sb[0] = b0; sb[1] = b1; dd[0] = d0; dd[1] = d1;
        @(negedge clk);
        ren_valid  = v;
        ren_dst_we = we;
        ren_src_a  = {AW'(a1), AW'(a0)};
        ren_src_b  = {AW'(b1), AW'(b0)};
        ren_dst    = {AW'(d1), AW'(d0)};
        cv = cv && (inf_tag.size() > 0);
        cmt_valid  = cv;
        cmt_arch   = cv ? AW'(inf_arch[0]) : '0;
        cmt_tag    = cv ? PW'(inf_tag[0]) : '0;
        flush      = fl;
        #1;
        need = 0;
        for (int i = 0; i < 2; i++) begin
            al[i] = v[i] && we[i] && dd[i] != 0;
            need += int'(al[i]);
        end
        rdy = !fl && fq.size() >= need;
        chk(fl ? "R8" : "R6", "ready", int'(ren_ready), int'(rdy));
        if (rdy) begin
            pos = 0;
            for (int i = 0; i < 2; i++) begin
                newt[i] = 0;
                if (al[i]) begin newt[i] = fq[pos]; pos++; end
            end
            for (int i = 0; i < 2; i++) begin
                if (v[i]) begin
                    ea = spec_m[sa[i]]; eb = spec_m[sb[i]]; ba = 0; bb = 0; bo = 0;
                    eo = al[i] ? spec_m[dd[i]] : 0;
                    if (i == 1 && al[0]) begin
                        if (dd[0] == sa[1]) begin ea = newt[0]; ba = 1; end
                        if (dd[0] == sb[1]) begin eb = newt[0]; bb = 1; end
                        if (al[1] && dd[0] == dd[1]) begin eo = newt[0]; bo = 1; end
                    end
                    chk(src_lbl(sa[i], ba, first), "src_a", int'(out_src_a[i*PW +: PW]), ea);
                    chk(src_lbl(sb[i], bb, first), "src_b", int'(out_src_b[i*PW +: PW]), eb);
                    if (al[i]) lb = recycled[newt[i]] ? "R7" : (first ? "R1" : "R3");
                    else lb = (we[i] && dd[i] == 0) ? "R2" : "R3";
                    chk(lb, "dst_new", int'(out_dst_new[i*PW +: PW]), newt[i]);
                    lb = bo ? "R5" : (post_flush ? "R8" : (al[i] ? "R4" : "R2"));
                    chk(lb, "dst_old", int'(out_dst_old[i*PW +: PW]), eo);
                end
            end
        end
        // model update: commit, then renames, then flush
        if (cv) begin
            recycled[cmt_m[inf_arch[0]]] = 1;
            fq.push_back(cmt_m[inf_arch[0]]);
            cmt_m[inf_arch[0]] = inf_tag[0];
            void'(inf_arch.pop_front());
            void'(inf_tag.pop_front());
        end
        if (rdy) begin
            for (int i = 0; i < 2; i++) begin
                if (al[i]) begin
                    void'(fq.pop_front());
                    spec_m[dd[i]] = newt[i];
                    inf_arch.push_back(dd[i]);
                    inf_tag.push_back(newt[i]);
                end
            end
        end
        if (fl) begin
            spec_m = cmt_m;
            fq = {inf_tag, fq};
            inf_tag.delete();
            inf_arch.delete();
        end
        post_flush = fl;
        @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL R6 watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int r, cp;
        rst_n = 0; ren_valid = 0; ren_dst_we = 0; ren_src_a = 0; ren_src_b = 0;
        ren_dst = 0; cmt_valid = 0; cmt_arch = 0; cmt_tag = 0; flush = 0;
        for (int i = 0; i < NARCH; i++) begin spec_m[i] = i; cmt_m[i] = i; end
        for (int i = NARCH; i < NPHYS; i++) fq.push_back(i);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1 reset map and free order, with R5 forwarding in the same group
        step(2'b11, 2'b11, 7, 0, 3, 3, 9, 3, 0, 0, 1);
        // R2/R3/R5 sweep of colliding registers
        for (int d0 = 0; d0 < 4; d0++)
            for (int d1 = 0; d1 < 4; d1++)
                for (int s = 0; s < 4; s++)
                    step(2'b11, 2'(s), s, d1, d0, d0, s, d1, 1, 0, 0);
        // R8 flush with commit in the same cycle, then check recovery
        step(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        step(2'b11, 2'b11, 1, 2, 1, 3, 1, 2, 0, 0, 0);
        // R6 exhaustion: no commits until the list runs dry
        for (int n = 0; n < 30; n++)
            step(2'b11, 2'b11, n % 32, 5, 1 + n % 31, 2, n % 32, 1 + (n * 7) % 31, 0, 0, 0);
        // R7 drain by commits, then mixed traffic
        for (int n = 0; n < 40; n++)
            step(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        for (int n = 0; n < 3000; n++) begin
            r  = (n / 500) % 2 == 0 ? 6 : 32;
            cp = (n / 250) % 3;
            step(2'(rnd(4)), 2'(rnd(4)), rnd(r), rnd(r), rnd(r), rnd(r), rnd(r), rnd(r),
                 rnd(4) < cp + 1, rnd(50) == 0, 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule